// File: doc/BRIEF.md
# Predicated Group Prediction Propagator

This block sits just ahead of register rename and takes one decoded instruction per cycle. Each instruction carries a 4-bit condition code and two flags: one marks an instruction that writes the condition flags, the other marks a branch. A run of conditional instructions that test the same flag state forms a group. The group starts at its first conditional instruction and ends after an instruction that writes the flags. Only that first instruction asks the external predictor for a value, and every later member reuses the answer. A member that tests the opposite condition receives the inverted answer. Each instruction leaves the block marked active (renamed normally) or no-op, and each group member also carries a group number. A later misprediction can therefore be matched to every member of its group.

The block also keeps a speculative global history register that holds both branch and predicate outcomes. Each group adds its value to this register exactly once, when the group opens. Each conditional branch adds its direction. A restore input reloads the history after a pipeline repair and discards any open group. The predictor tables are outside the block: `pred_req` asks for a prediction in the same cycle, and `pred_value` returns it combinationally.

Top module: `pgp_propagator`

## Requirements
- R1: After reset `out_valid` is 0 and `hist` is all zeros. No group is open, so the first conditional instruction opens group number 1.
- R2: Condition codes 14 and 15 mean "always". Such an instruction, or any branch, leaves with `out_member`=0 and `out_active`=1. It neither opens nor joins a group.
- R3: A non-branch instruction with condition c (c<14) opens a new group in two cases: no group is open, or the open group's condition differs from c in bits [3:1]. `pred_req` is high in that cycle exactly when `in_known_valid` is low. Members that join an open group never raise `pred_req`.
- R4: Codes 2k and 2k+1 are opposite conditions. A joining member whose bit 0 differs from the group's opening condition takes the inverted group value. `out_active`=1 means the member is renamed, and 0 means it becomes a no-op.
- R5: A member with `in_known_valid`=1 takes `in_known_value` as its `out_active`, and the prediction is not used. When this happens on the opening instruction, the known value also becomes the group value that later members use.
- R6: `hist` shifts left by one bit, with the new bit entering at bit 0, only in two cases. When a group opens, the shifted-in bit is the group value. When a conditional branch (code <14) arrives, the shifted-in bit is `in_br_taken`. No other instruction changes `hist`.
- R7: An instruction with `in_sets_flags`=1 is first handled as usual, and it may open a group itself. The group is closed after it, so the next conditional instruction opens a new group.
- R8: Each group opening adds one to the group number, modulo 2^GID_W. The number does not change otherwise. Every member leaves with its group's number on `out_gid`, and the opening member also has `out_first`=1.
- R9: `restore_valid` loads `hist` with `restore_hist` and closes any open group. It takes priority over an instruction presented in the same cycle, which is dropped with no output.
- R10: Outputs are registered. An instruction presented before a clock edge appears on the `out_*` ports right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_cond | input | 4 | Condition code (14/15 = always, 2k/2k+1 opposite) |
| in_sets_flags | input | 1 | Instruction writes the condition flags |
| in_is_branch | input | 1 | Instruction is a branch |
| in_br_taken | input | 1 | Predicted direction of a conditional branch |
| in_known_valid | input | 1 | Real predicate value is already known |
| in_known_value | input | 1 | Real predicate value of this instruction |
| pred_value | input | 1 | Predictor answer for the requesting instruction |
| pred_req | output | 1 | Request for one prediction (group opening) |
| restore_valid | input | 1 | Reload history and drop the open group |
| restore_hist | input | HIST_W | History value to reload |
| out_valid | output | 1 | Output instruction present |
| out_cond | output | 4 | Condition code passed through |
| out_member | output | 1 | Instruction belongs to a group |
| out_first | output | 1 | Instruction opened its group |
| out_active | output | 1 | 1 = rename normally, 0 = no-op |
| out_gid | output | GID_W | Group number of a member |
| hist | output | HIST_W | Speculative branch-and-predicate history |

## Verification
The bench builds the block with HIST_W=8 and GID_W=3. With these values, the effect of every shift on the history register can be checked against a value computed in the bench. After eight openings the group number wraps from 7 to 0, which a short directed run reaches. The tests cover several other cases: inversion of the group value for opposite codes, a known value overriding the prediction, a conditional flag-writer that opens and closes a group in the same cycle, and a restore that collides with an instruction.

// File: rtl/pgp_pkg.sv
package pgp_pkg;
  localparam int COND_W = 4;
  typedef logic [COND_W-1:0] cond_t;

  // codes 14 and 15 are the unconditional encodings
  function automatic logic cond_always(cond_t c);
    return c[3:1] == 3'b111;
  endfunction

  // two codes test the same flag state when they share bits [3:1]
  function automatic logic cond_same_pair(cond_t a, cond_t b);
    return a[3:1] == b[3:1];
  endfunction

  // bit 0 selects the sense within a pair
  function automatic logic cond_inverts(cond_t a, cond_t b);
    return a[0] ^ b[0];
  endfunction

  function automatic logic pick_value(logic known_v, logic known, logic fallback);
    return known_v ? known : fallback;
  endfunction
endpackage

// File: rtl/pgp_resolve.sv
module pgp_resolve
  import pgp_pkg::*;
(
  input  logic  valid,
  input  cond_t cond,
  input  logic  sets_flags,
  input  logic  is_branch,
  input  logic  br_taken,
  input  logic  known_valid,
  input  logic  known_value,
  input  logic  pred_value,
  input  logic  grp_open,
  input  cond_t grp_cond,
  input  logic  grp_val,
  output logic  member,
  output logic  open_evt,
  output logic  open_val,
  output logic  close_evt,
  output logic  active,
  output logic  shift_en,
  output logic  shift_bit
);
  logic uncond;
  logic cond_instr;
  logic joins;
  logic base_val;
  logic inv;

  always_comb begin
    uncond     = cond_always(cond);
    cond_instr = valid && !uncond && !is_branch;
    joins      = grp_open && cond_same_pair(cond, grp_cond);
    open_evt   = cond_instr && !joins;
    member     = cond_instr;
    open_val   = pick_value(known_valid, known_value, pred_value);
    base_val   = open_evt ? open_val : grp_val;
    inv        = open_evt ? 1'b0 : cond_inverts(cond, grp_cond);
    if (cond_instr)
      active = pick_value(known_valid, known_value, base_val ^ inv);
    else
      active = 1'b1;
    close_evt  = valid && sets_flags;
    shift_en   = open_evt || (valid && is_branch && !uncond);
    shift_bit  = open_evt ? open_val : br_taken;
  end
endmodule

// File: rtl/pgp_group_tracker.sv
module pgp_group_tracker
  import pgp_pkg::*;
#(
  parameter int GID_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             open_evt,
  input  logic             close_evt,
  input  cond_t            open_cond,
  input  logic             open_val,
  output logic             grp_open,
  output cond_t            grp_cond,
  output logic             grp_val,
  output logic [GID_W-1:0] grp_id,
  output logic [GID_W-1:0] next_id
);
  assign next_id = grp_id + GID_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp_open <= 1'b0;
      grp_cond <= '0;
      grp_val  <= 1'b0;
      grp_id   <= '0;
    end else if (flush) begin
      grp_open <= 1'b0;
    end else begin
      if (open_evt) begin
        grp_cond <= open_cond;
        grp_val  <= open_val;
        grp_id   <= next_id;
        grp_open <= !close_evt;
      end else if (close_evt) begin
        grp_open <= 1'b0;
      end
    end
  end

  a_r7_close_after_flags: assert property (@(posedge clk) disable iff (!rst_n)
    close_evt |=> !grp_open);
  a_r8_gid_step: assert property (@(posedge clk) disable iff (!rst_n)
    (open_evt && !flush) |=> GID_W'(grp_id - $past(grp_id)) == GID_W'(1));
  a_r8_gid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !open_evt |=> $stable(grp_id));
  a_r9_flush_closes: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !grp_open);
endmodule

// File: rtl/pgp_history.sv
module pgp_history #(
  parameter int HIST_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [HIST_W-1:0] load_val,
  input  logic              shift_en,
  input  logic              shift_bit,
  output logic [HIST_W-1:0] hist
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      hist <= '0;
    else if (load)
      hist <= load_val;
    else if (shift_en)
      hist <= {hist[HIST_W-2:0], shift_bit};
  end

  a_r6_hist_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift_en) |=> $stable(hist));
  a_r6_hist_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && shift_en) |=> hist[HIST_W-1:1] == $past(hist[HIST_W-2:0]));
  a_r9_hist_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> hist == $past(load_val));
endmodule

// File: rtl/pgp_propagator.sv
module pgp_propagator
  import pgp_pkg::*;
#(
  parameter int HIST_W = 16,
  parameter int GID_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        in_cond,
  input  logic              in_sets_flags,
  input  logic              in_is_branch,
  input  logic              in_br_taken,
  input  logic              in_known_valid,
  input  logic              in_known_value,
  input  logic              pred_value,
  output logic              pred_req,
  input  logic              restore_valid,
  input  logic [HIST_W-1:0] restore_hist,
  output logic              out_valid,
  output logic [3:0]        out_cond,
  output logic              out_member,
  output logic              out_first,
  output logic              out_active,
  output logic [GID_W-1:0]  out_gid,
  output logic [HIST_W-1:0] hist
);
  logic             live;
  logic             member, open_evt, open_val, close_evt, active;
  logic             shift_en, shift_bit;
  logic             grp_open, grp_val;
  cond_t            grp_cond;
  logic [GID_W-1:0] grp_id, next_id;

  // a restore wins over an instruction in the same cycle
  assign live = in_valid && !restore_valid;

  pgp_resolve u_resolve (
    .valid       (live),
    .cond        (in_cond),
    .sets_flags  (in_sets_flags),
    .is_branch   (in_is_branch),
    .br_taken    (in_br_taken),
    .known_valid (in_known_valid),
    .known_value (in_known_value),
    .pred_value  (pred_value),
    .grp_open    (grp_open),
    .grp_cond    (grp_cond),
    .grp_val     (grp_val),
    .member      (member),
    .open_evt    (open_evt),
    .open_val    (open_val),
    .close_evt   (close_evt),
    .active      (active),
    .shift_en    (shift_en),
    .shift_bit   (shift_bit)
  );

  pgp_group_tracker #(.GID_W(GID_W)) u_tracker (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (restore_valid),
    .open_evt  (open_evt),
    .close_evt (close_evt),
    .open_cond (in_cond),
    .open_val  (open_val),
    .grp_open  (grp_open),
    .grp_cond  (grp_cond),
    .grp_val   (grp_val),
    .grp_id    (grp_id),
    .next_id   (next_id)
  );

  pgp_history #(.HIST_W(HIST_W)) u_history (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (restore_valid),
    .load_val  (restore_hist),
    .shift_en  (shift_en),
    .shift_bit (shift_bit),
    .hist      (hist)
  );

  assign pred_req = open_evt && !in_known_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_cond   <= '0;
      out_member <= 1'b0;
      out_first  <= 1'b0;
      out_active <= 1'b0;
      out_gid    <= '0;
    end else begin
      out_valid  <= live;
      out_cond   <= in_cond;
      out_member <= member;
      out_first  <= open_evt;
      out_active <= active;
      out_gid    <= open_evt ? next_id : grp_id;
    end
  end

  a_r2_nonmember_active: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_member) |-> out_active);
  a_r3_req_only_unknown: assert property (@(posedge clk) disable iff (!rst_n)
    pred_req |-> (in_valid && !in_known_valid && !restore_valid));
  a_r8_first_is_member: assert property (@(posedge clk) disable iff (!rst_n)
    out_first |-> (out_member && out_valid));
  a_r9_restore_drops: assert property (@(posedge clk) disable iff (!rst_n)
    restore_valid |=> !out_valid);
endmodule

// File: tb/pgp_propagator_bench.sv
module pgp_propagator_bench;
  localparam int HW = 8;
  localparam int GW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid, in_sets_flags, in_is_branch, in_br_taken;
  logic [3:0]    in_cond;
  logic          in_known_valid, in_known_value, pred_value, pred_req;
  logic          restore_valid;
  logic [HW-1:0] restore_hist;
  logic          out_valid, out_member, out_first, out_active;
  logic [3:0]    out_cond;
  logic [GW-1:0] out_gid;
  logic [HW-1:0] hist;

  int checks = 0;
  int errors = 0;
  logic [HW-1:0] exp_hist;
  logic [GW-1:0] exp_gid;

  always #2.5 clk = ~clk;

  pgp_propagator #(.HIST_W(HW), .GID_W(GW)) u_pgp_propagator (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cond(in_cond),
    .in_sets_flags(in_sets_flags), .in_is_branch(in_is_branch),
    .in_br_taken(in_br_taken), .in_known_valid(in_known_valid),
    .in_known_value(in_known_value), .pred_value(pred_value),
    .pred_req(pred_req), .restore_valid(restore_valid),
    .restore_hist(restore_hist), .out_valid(out_valid), .out_cond(out_cond),
    .out_member(out_member), .out_first(out_first), .out_active(out_active),
    .out_gid(out_gid), .hist(hist)
  );

  task automatic chk(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic idle();
    in_valid = 0; in_cond = 4'd14; in_sets_flags = 0; in_is_branch = 0;
    in_br_taken = 0; in_known_valid = 0; in_known_value = 0; pred_value = 0;
    restore_valid = 0; restore_hist = '0;
  endtask

  // drive one instruction at the falling edge, check pred_req, then
  // sample the registered outputs just after the next rising edge (R10)
  task automatic issue(string req, input logic [3:0] c, input logic fl,
                       input logic br, input logic bt, input logic kv,
                       input logic kval, input logic pv, input logic exp_req);
    @(negedge clk);
    in_valid = 1; in_cond = c; in_sets_flags = fl; in_is_branch = br;
    in_br_taken = bt; in_known_valid = kv; in_known_value = kval; pred_value = pv;
    #1;
    chk(req, "pred_req", pred_req, exp_req);
    @(posedge clk);
    #1;
    idle();
    chk("R10", "out_valid", out_valid, 1);
    chk(req, "out_cond", out_cond, c);
  endtask

  task automatic expect_out(string req, logic mem, logic first, logic act);
    chk(req, "out_member", out_member, mem);
    chk(req, "out_first", out_first, first);
    chk(req, "out_active", out_active, act);
    if (mem) chk(req, "out_gid", out_gid, exp_gid);
    chk(req, "hist", hist, exp_hist);
  endtask

  function automatic logic [HW-1:0] sh(logic [HW-1:0] h, logic b);
    return {h[HW-2:0], b};
  endfunction

  task automatic t_reset();
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    chk("R1", "out_valid after reset", out_valid, 0);
    chk("R1", "hist after reset", hist, 0);
    exp_hist = '0; exp_gid = '0;
  endtask

  task automatic t_always();
    issue("R2", 4'd14, 0, 0, 0, 0, 0, 1, 0);
    expect_out("R2", 0, 0, 1);
    issue("R2", 4'd15, 0, 0, 0, 0, 0, 0, 0);
    expect_out("R2", 0, 0, 1);
  endtask

  task automatic t_group();
    // R1: first conditional opens group 1
    issue("R3", 4'd0, 0, 0, 0, 0, 0, 1, 1);
    exp_gid = exp_gid + 1; exp_hist = sh(exp_hist, 1);
    chk("R1", "first gid", out_gid, 1);
    expect_out("R3", 1, 1, 1);
    // R4 opposite member gets inverted value, no new request, no shift
    issue("R4", 4'd1, 0, 0, 0, 0, 0, 1, 0);
    expect_out("R4", 1, 0, 0);
    issue("R4", 4'd0, 0, 0, 0, 0, 0, 0, 0);
    expect_out("R4", 1, 0, 1);
    // R7 unconditional flag writer closes
    issue("R7", 4'd14, 1, 0, 0, 0, 0, 0, 0);
    expect_out("R7", 0, 0, 1);
    issue("R7", 4'd1, 0, 0, 0, 0, 0, 1, 1);
    exp_gid = exp_gid + 1; exp_hist = sh(exp_hist, 1);
    expect_out("R7", 1, 1, 1);
  endtask

  task automatic t_diffpair();
    issue("R3", 4'd2, 0, 0, 0, 0, 0, 0, 1);
    exp_gid = exp_gid + 1; exp_hist = sh(exp_hist, 0);
    expect_out("R3", 1, 1, 0);
    issue("R3", 4'd4, 0, 0, 0, 0, 0, 1, 1);
    exp_gid = exp_gid + 1; exp_hist = sh(exp_hist, 1);
    expect_out("R3", 1, 1, 1);
  endtask

  task automatic t_known();
    issue("R5", 4'd6, 0, 0, 0, 1, 1, 0, 0);
    exp_gid = exp_gid + 1; exp_hist = sh(exp_hist, 1);
    expect_out("R5", 1, 1, 1);
    issue("R5", 4'd7, 0, 0, 0, 0, 0, 1, 0);
    expect_out("R5", 1, 0, 0);
    issue("R5", 4'd6, 0, 0, 0, 1, 0, 1, 0);
    expect_out("R5", 1, 0, 0);
  endtask

  task automatic t_branch();
    issue("R6", 4'd0, 0, 1, 1, 0, 0, 0, 0);
    exp_hist = sh(exp_hist, 1);
    expect_out("R6", 0, 0, 1);
    issue("R6", 4'd3, 0, 1, 0, 0, 0, 0, 0);
    exp_hist = sh(exp_hist, 0);
    expect_out("R6", 0, 0, 1);
    issue("R6", 4'd14, 0, 1, 1, 0, 0, 0, 0);
    expect_out("R6", 0, 0, 1);
    // group on code 6/7 still open after branches
    issue("R6", 4'd7, 0, 0, 0, 0, 0, 0, 0);
    expect_out("R6", 1, 0, 0);
  endtask

  task automatic t_flagcond();
    issue("R7", 4'd8, 1, 0, 0, 0, 0, 1, 1);
    exp_gid = exp_gid + 1; exp_hist = sh(exp_hist, 1);
    expect_out("R7", 1, 1, 1);
    issue("R7", 4'd9, 0, 0, 0, 0, 0, 1, 1);
    exp_gid = exp_gid + 1; exp_hist = sh(exp_hist, 1);
    expect_out("R7", 1, 1, 1);
  endtask

  task automatic t_restore();
    @(negedge clk);
    in_valid = 1; in_cond = 4'd9; pred_value = 1;
    restore_valid = 1; restore_hist = 8'hA5;
    #1;
    chk("R9", "pred_req during restore", pred_req, 0);
    @(posedge clk); #1;
    idle();
    exp_hist = 8'hA5;
    chk("R9", "dropped instruction", out_valid, 0);
    chk("R9", "hist loaded", hist, exp_hist);
    issue("R9", 4'd9, 0, 0, 0, 0, 0, 0, 1);
    exp_gid = exp_gid + 1; exp_hist = sh(exp_hist, 0);
    expect_out("R9", 1, 1, 0);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 9; i++) begin
      issue("R8", 4'd10, 1, 0, 0, 0, 0, i[0], 1);
      exp_gid = exp_gid + 1; exp_hist = sh(exp_hist, i[0]);
      expect_out("R8", 1, 1, i[0]);
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_always();
    t_group();
    t_diffpair();
    t_known();
    t_branch();
    t_flagcond();
    t_restore();
    t_wrap();
    repeat (2) @(posedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule